// File: doc/BRIEF.md
# Configurable Lookup-Table Logic Tile

This block is one programmable logic tile of the kind found in a fabric of look-up-table cells. It holds eight cells. Each cell combines a four-input truth table, an optional carry stage and an optional storage flip-flop. All behaviour is set by a static parallel configuration. The configuration gives sixteen truth-table bits per cell, per-cell enables for the carry stage and the flip-flop, a per-cell reset style and reset value, and tile-wide choices for the carry-chain source and the clock edge.

The carry stage uses the cell's inputs 1 and 2 as its two operands, which is enough for ripple arithmetic across the tile. The chain starts from a selectable source and leaves the tile from the topmost cell. Clock, clock enable and the set/reset line are shared by every cell. Each flip-flop treats set/reset either as a clocked load, which is gated by the clock enable, or as an immediate force.

Top module: `lut_tile`

## Requirements
- R1: A cell's look-up result is bit number k of its 16-bit truth table, where k = {in3,in2,in1,in0} and in0 is bit 0 of that cell's 4-bit input.
- R2: A cell whose flip-flop enable is 0 drives its look-up result on its output with no clock involved. A cell whose flip-flop enable is 1 drives the register contents, which do not follow an input change until the next active edge.
- R3: With carry enabled, a cell's carry-out is (in1 AND in2) OR ((in1 OR in2) AND carry-in).
- R4: With carry disabled, a cell passes its carry-in unchanged to its carry-out.
- R5: Cell 0 takes its carry-in from the tile carry input when the chain-source select is 1, and from the constant configuration bit when it is 0. Each higher cell takes the carry-out of the cell below it. The tile carry output is the carry-out of cell 7.
- R6: In clocked-reset mode a flip-flop changes only at an active edge with clock enable 1. It then loads its reset value if set/reset is 1, and its look-up result otherwise. With clock enable 0 it holds, even while set/reset is 1.
- R7: In immediate-reset mode a flip-flop takes its reset value as soon as set/reset is 1, with no clock edge and whatever the clock enable. While set/reset is 0 it loads its look-up result at an active edge with clock enable 1.
- R8: With the tile-wide edge select at 1, every flip-flop captures on the falling clock edge and ignores the rising edge. With the select at 0, the flip-flops capture on the rising edge.
- R9: Set/reset has no effect on the output of a cell whose flip-flop enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared tile clock |
| clkEn | input | 1 | Shared clock enable for all flip-flops |
| setReset | input | 1 | Shared set/reset line |
| carryIn | input | 1 | Carry from the tile below |
| cellIn | input | NUM_CELLS x LUT_INPUTS | Data inputs per cell, bit 0 is in0 |
| lutTable | input | NUM_CELLS x 2^LUT_INPUTS | Truth table per cell |
| carryEnable | input | NUM_CELLS | Per-cell carry stage enable |
| ffEnable | input | NUM_CELLS | Per-cell registered output select |
| asyncMode | input | NUM_CELLS | Per-cell reset style, 1 = immediate |
| resetValue | input | NUM_CELLS | Per-cell value loaded or forced by set/reset |
| cascadeSel | input | 1 | Chain source for cell 0, 1 = carryIn |
| cascadeConst | input | 1 | Constant chain source for cell 0 |
| fallingEdge | input | 1 | 1 = flip-flops capture on the falling clock edge |
| cellOut | output | NUM_CELLS | Per-cell outputs |
| carryOut | output | 1 | Carry-out of the topmost cell |

## Verification
Look-up results and the carry chain are combinational, so the bench checks them 1 ns after it drives the inputs, with no clock edge in between. A registered result is due at the first active edge after the stimulus. The bench changes inputs away from the edges and samples 2 ns after the edge it expects, rising or falling as the edge select demands. It also samples once before that edge, to show that nothing has moved early. An immediate reset is checked 1 ns after set/reset rises, well before the next edge, and again after a later edge with clock enable low.

// File: rtl/lut_tile_pkg.sv
package lut_tile_pkg;

  // Strobes sent by the control unit to each cell's flip-flop.
  typedef struct packed {
    logic capture;      // active edge may update the register
    logic loadPreset;   // clocked load of the reset value
    logic forcePreset;  // immediate force of the reset value
  } cellStrobe_t;

  function automatic logic carryMajority(input logic opA, input logic opB, input logic cin);
    return (opA & opB) | ((opA | opB) & cin);
  endfunction

endpackage

// File: rtl/lut_tile_lut.sv
module lut_tile_lut #(
  parameter int unsigned LUT_INPUTS = 4,
  localparam int unsigned LUT_BITS = 1 << LUT_INPUTS
) (
  input  logic [LUT_BITS-1:0]   truthTable,
  input  logic [LUT_INPUTS-1:0] sel,
  output logic                  result
);

  // Binary mux tree: level 0 holds the table, each level halves the width
  // using one select bit, starting from the least significant input.
  logic [LUT_BITS-1:0] stage [LUT_INPUTS+1];

  assign stage[0] = truthTable;

  for (genvar lvl = 0; lvl < LUT_INPUTS; lvl++) begin : gLevel
    localparam int unsigned WIDTH = LUT_BITS >> (lvl + 1);
    for (genvar k = 0; k < LUT_BITS; k++) begin : gBit
      if (k < WIDTH) begin : gMux
        assign stage[lvl+1][k] = sel[lvl] ? stage[lvl][2*k+1] : stage[lvl][2*k];
      end else begin : gPad
        assign stage[lvl+1][k] = 1'b0;
      end
    end
  end

  assign result = stage[LUT_INPUTS][0];

endmodule

// File: rtl/lut_tile_carry.sv
module lut_tile_carry
  import lut_tile_pkg::*;
#(
  parameter int unsigned NUM_CELLS = 8
) (
  input  logic                 carryIn,
  input  logic                 cascadeSel,
  input  logic                 cascadeConst,
  input  logic [NUM_CELLS-1:0] carryEnable,
  input  logic [NUM_CELLS-1:0] opA,
  input  logic [NUM_CELLS-1:0] opB,
  output logic                 carryOut
);

  logic [NUM_CELLS:0] chain;

  assign chain[0] = cascadeSel ? carryIn : cascadeConst;

  for (genvar g = 0; g < NUM_CELLS; g++) begin : gStage
    assign chain[g+1] = carryEnable[g] ? carryMajority(opA[g], opB[g], chain[g]) : chain[g];
  end

  assign carryOut = chain[NUM_CELLS];

endmodule

// File: rtl/lut_tile_ctrl.sv
module lut_tile_ctrl
  import lut_tile_pkg::*;
#(
  parameter int unsigned NUM_CELLS = 8
) (
  input  logic                   clk,
  input  logic                   fallingEdge,
  input  logic                   clkEn,
  input  logic                   setReset,
  input  logic [NUM_CELLS-1:0]   asyncMode,
  output logic                   tileClk,
  output cellStrobe_t [NUM_CELLS-1:0] strobes
);

  // Edge select is static configuration: inverting the clock makes every
  // flip-flop capture on the falling edge of clk.
  assign tileClk = clk ^ fallingEdge;

  for (genvar g = 0; g < NUM_CELLS; g++) begin : gCell
    always_comb begin
      strobes[g].capture     = clkEn;
      strobes[g].loadPreset  = setReset & ~asyncMode[g];
      strobes[g].forcePreset = setReset &  asyncMode[g];
    end
  end

endmodule

// File: rtl/lut_tile_datapath.sv
module lut_tile_datapath
  import lut_tile_pkg::*;
#(
  parameter int unsigned NUM_CELLS  = 8,
  parameter int unsigned LUT_INPUTS = 4,
  localparam int unsigned LUT_BITS  = 1 << LUT_INPUTS
) (
  input  logic                                 tileClk,
  input  cellStrobe_t [NUM_CELLS-1:0]          strobes,
  input  logic [NUM_CELLS-1:0][LUT_INPUTS-1:0] cellIn,
  input  logic [NUM_CELLS-1:0][LUT_BITS-1:0]   lutTable,
  input  logic [NUM_CELLS-1:0]                 carryEnable,
  input  logic [NUM_CELLS-1:0]                 ffEnable,
  input  logic [NUM_CELLS-1:0]                 resetValue,
  input  logic                                 carryIn,
  input  logic                                 cascadeSel,
  input  logic                                 cascadeConst,
  output logic [NUM_CELLS-1:0]                 cellOut,
  output logic                                 carryOut
);

  logic [NUM_CELLS-1:0] lutResult;
  logic [NUM_CELLS-1:0] regQ;
  logic [NUM_CELLS-1:0] forceNet;
  logic [NUM_CELLS-1:0] opA;
  logic [NUM_CELLS-1:0] opB;

  for (genvar g = 0; g < NUM_CELLS; g++) begin : gCell
    logic q;

    lut_tile_lut #(.LUT_INPUTS(LUT_INPUTS)) uLut (
      .truthTable (lutTable[g]),
      .sel        (cellIn[g]),
      .result     (lutResult[g])
    );

    assign forceNet[g] = strobes[g].forcePreset;

    always_ff @(posedge tileClk or posedge forceNet[g]) begin
      if (forceNet[g]) begin
        q <= resetValue[g];
      end else if (strobes[g].capture) begin
        q <= strobes[g].loadPreset ? resetValue[g] : lutResult[g];
      end
    end

    assign regQ[g]    = q;
    assign cellOut[g] = ffEnable[g] ? regQ[g] : lutResult[g];
    assign opA[g]     = cellIn[g][1];
    assign opB[g]     = cellIn[g][2];
  end

  lut_tile_carry #(.NUM_CELLS(NUM_CELLS)) uCarry (
    .carryIn      (carryIn),
    .cascadeSel   (cascadeSel),
    .cascadeConst (cascadeConst),
    .carryEnable  (carryEnable),
    .opA          (opA),
    .opB          (opB),
    .carryOut     (carryOut)
  );

endmodule

// File: rtl/lut_tile.sv
module lut_tile
  import lut_tile_pkg::*;
#(
  parameter int unsigned NUM_CELLS  = 8,
  parameter int unsigned LUT_INPUTS = 4
) (
  input  logic                                          clk,
  input  logic                                          clkEn,
  input  logic                                          setReset,
  input  logic                                          carryIn,
  input  logic [NUM_CELLS-1:0][LUT_INPUTS-1:0]          cellIn,
  input  logic [NUM_CELLS-1:0][(1 << LUT_INPUTS)-1:0]   lutTable,
  input  logic [NUM_CELLS-1:0]                          carryEnable,
  input  logic [NUM_CELLS-1:0]                          ffEnable,
  input  logic [NUM_CELLS-1:0]                          asyncMode,
  input  logic [NUM_CELLS-1:0]                          resetValue,
  input  logic                                          cascadeSel,
  input  logic                                          cascadeConst,
  input  logic                                          fallingEdge,
  output logic [NUM_CELLS-1:0]                          cellOut,
  output logic                                          carryOut
);

  logic                        tileClk;
  cellStrobe_t [NUM_CELLS-1:0] strobes;

  lut_tile_ctrl #(.NUM_CELLS(NUM_CELLS)) uCtrl (
    .clk         (clk),
    .fallingEdge (fallingEdge),
    .clkEn       (clkEn),
    .setReset    (setReset),
    .asyncMode   (asyncMode),
    .tileClk     (tileClk),
    .strobes     (strobes)
  );

  lut_tile_datapath #(.NUM_CELLS(NUM_CELLS), .LUT_INPUTS(LUT_INPUTS)) uData (
    .tileClk      (tileClk),
    .strobes      (strobes),
    .cellIn       (cellIn),
    .lutTable     (lutTable),
    .carryEnable  (carryEnable),
    .ffEnable     (ffEnable),
    .resetValue   (resetValue),
    .carryIn      (carryIn),
    .cascadeSel   (cascadeSel),
    .cascadeConst (cascadeConst),
    .cellOut      (cellOut),
    .carryOut     (carryOut)
  );

endmodule

// File: rtl/lut_tile_checker.sv
module lut_tile_checker #(
  parameter int unsigned NUM_CELLS  = 8,
  parameter int unsigned LUT_INPUTS = 4
) (
  input logic                                        clk,
  input logic                                        clkEn,
  input logic                                        setReset,
  input logic                                        carryIn,
  input logic [NUM_CELLS-1:0][LUT_INPUTS-1:0]        cellIn,
  input logic [NUM_CELLS-1:0][(1 << LUT_INPUTS)-1:0] lutTable,
  input logic [NUM_CELLS-1:0]                        carryEnable,
  input logic [NUM_CELLS-1:0]                        ffEnable,
  input logic [NUM_CELLS-1:0]                        asyncMode,
  input logic [NUM_CELLS-1:0]                        resetValue,
  input logic                                        cascadeSel,
  input logic                                        cascadeConst,
  input logic                                        fallingEdge,
  input logic [NUM_CELLS-1:0]                        cellOut,
  input logic                                        carryOut
);

  AST_CHAIN_BYPASS: assert property (@(posedge clk)
    (carryEnable == '0) |-> (carryOut == (cascadeSel ? carryIn : cascadeConst))); // R4

  for (genvar g = 0; g < NUM_CELLS; g++) begin : gCell
    AST_COMB_OUTPUT: assert property (@(posedge clk)
      !ffEnable[g] |-> (cellOut[g] == lutTable[g][cellIn[g]])); // R2

    AST_FORCE_NOW: assert property (@(posedge clk)
      (ffEnable[g] && asyncMode[g] && setReset) |-> (cellOut[g] == resetValue[g])); // R7

    AST_HOLD_NO_ENABLE: assert property (@(posedge clk) disable iff (setReset)
      (ffEnable[g] && !asyncMode[g] && !fallingEdge && !clkEn)
      |=> ($stable(cellOut[g]) || !$stable({ffEnable[g], asyncMode[g], fallingEdge}))); // R6

    AST_SYNC_PRESET: assert property (@(posedge clk)
      (ffEnable[g] && !asyncMode[g] && !fallingEdge && clkEn && setReset)
      |=> ((cellOut[g] == $past(resetValue[g])) ||
           !$stable({ffEnable[g], asyncMode[g], fallingEdge}))); // R6
  end

endmodule

bind lut_tile lut_tile_checker #(.NUM_CELLS(NUM_CELLS), .LUT_INPUTS(LUT_INPUTS)) uChecker (
  .clk          (clk),
  .clkEn        (clkEn),
  .setReset     (setReset),
  .carryIn      (carryIn),
  .cellIn       (cellIn),
  .lutTable     (lutTable),
  .carryEnable  (carryEnable),
  .ffEnable     (ffEnable),
  .asyncMode    (asyncMode),
  .resetValue   (resetValue),
  .cascadeSel   (cascadeSel),
  .cascadeConst (cascadeConst),
  .fallingEdge  (fallingEdge),
  .cellOut      (cellOut),
  .carryOut     (carryOut)
);

// File: tb/lut_tile_test.sv
module lut_tile_test;

  localparam int CELLS = 8;
  localparam int WATCHDOG_NS = 20 * 100000;

  // Adder vectors: {a, b, carry in, expected tile carry out}
  localparam logic [17:0] ADD_VEC [10] = '{
    {8'hFF, 8'h01, 1'b0, 1'b1},
    {8'hFF, 8'h00, 1'b0, 1'b0},
    {8'hFF, 8'h00, 1'b1, 1'b1},
    {8'h80, 8'h80, 1'b0, 1'b1},
    {8'h7F, 8'h80, 1'b0, 1'b0},
    {8'h7F, 8'h80, 1'b1, 1'b1},
    {8'h00, 8'h00, 1'b1, 1'b0},
    {8'hAA, 8'h55, 1'b0, 1'b0},
    {8'hAA, 8'h56, 1'b0, 1'b1},
    {8'h12, 8'h34, 1'b1, 1'b0}
  };

  logic clk = 1'b0;
  logic clkEn, setReset, carryIn, cascadeSel, cascadeConst, fallingEdge;
  logic [CELLS-1:0][3:0]  cellIn;
  logic [CELLS-1:0][15:0] lutTable;
  logic [CELLS-1:0] carryEnable, ffEnable, asyncMode, resetValue;
  logic [CELLS-1:0] cellOut;
  logic carryOut;

  int checkCount = 0;
  int failCount  = 0;

  always #10 clk = ~clk;

  lut_tile uut (
    .clk(clk), .clkEn(clkEn), .setReset(setReset), .carryIn(carryIn),
    .cellIn(cellIn), .lutTable(lutTable), .carryEnable(carryEnable),
    .ffEnable(ffEnable), .asyncMode(asyncMode), .resetValue(resetValue),
    .cascadeSel(cascadeSel), .cascadeConst(cascadeConst),
    .fallingEdge(fallingEdge), .cellOut(cellOut), .carryOut(carryOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic stepRise();
    @(posedge clk);
    #2;
  endtask

  task automatic stepFall();
    @(negedge clk);
    #2;
  endtask

  // Drive in0 of every cell from one bit of the pattern, other inputs 0.
  task automatic driveIn0(input logic [CELLS-1:0] pattern);
    for (int i = 0; i < CELLS; i++) cellIn[i] = {3'b000, pattern[i]};
  endtask

  // Truth table built from R1: entry k holds f applied to index bits of k.
  function automatic logic [15:0] tableXor12();
    logic [15:0] t;
    for (int k = 0; k < 16; k++) t[k] = k[1] ^ k[2];
    return t;
  endfunction

  function automatic logic [15:0] tablePass0();
    logic [15:0] t;
    for (int k = 0; k < 16; k++) t[k] = k[0];
    return t;
  endfunction

  initial begin
    #(WATCHDOG_NS);
    failCount++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    logic [CELLS-1:0] expOut;
    clkEn = 1'b1; setReset = 1'b0; carryIn = 1'b0; cascadeSel = 1'b1;
    cascadeConst = 1'b0; fallingEdge = 1'b0;
    cellIn = '0; lutTable = '0; carryEnable = '0; ffEnable = '0;
    asyncMode = '0; resetValue = '0;

    // Reset state: clocked preset loads the reset value (R6)
    ffEnable = '1; resetValue = 8'hA5; setReset = 1'b1;
    stepRise();
    check("R6 reset state", cellOut, 8'hA5);
    setReset = 1'b0;

    // R1: random truth tables, combinational path
    stepFall();
    ffEnable = '0;
    for (int t = 0; t < 6; t++) begin
      for (int i = 0; i < CELLS; i++) begin
        lutTable[i] = 16'($urandom);
        cellIn[i]   = 4'($urandom);
      end
      #1;
      for (int i = 0; i < CELLS; i++) expOut[i] = lutTable[i][cellIn[i]];
      check("R1 random table", cellOut, expOut);
    end

    // R3/R5 vector table: ripple carry over all cells, LUT gives in1^in2
    for (int i = 0; i < CELLS; i++) lutTable[i] = tableXor12();
    carryEnable = '1; cascadeSel = 1'b1;
    for (int v = 0; v < 10; v++) begin
      logic [7:0] a, b;
      a = ADD_VEC[v][17:10];
      b = ADD_VEC[v][9:2];
      carryIn = ADD_VEC[v][1];
      for (int i = 0; i < CELLS; i++) cellIn[i] = {1'b0, b[i], a[i], 1'b0};
      #1;
      check("R3 ripple carry", carryOut, ADD_VEC[v][0]);
      check("R1 half sum", cellOut, a ^ b);
    end

    // R4: disabled stages pass carry through
    carryEnable = '0;
    for (int i = 0; i < CELLS; i++) cellIn[i] = 4'b0110;
    carryIn = 1'b0; #1;
    check("R4 bypass low", carryOut, 1'b0);
    carryIn = 1'b1; #1;
    check("R4 bypass high", carryOut, 1'b1);

    // R3: only the top stage enabled, generates then kills
    carryEnable = 8'h80; carryIn = 1'b0; #1;
    check("R3 top generate", carryOut, 1'b1);
    cellIn[7] = 4'b0000; carryIn = 1'b1; #1;
    check("R3 top kill", carryOut, 1'b0);

    // R5: chain source select
    carryEnable = '0; cascadeSel = 1'b0; cascadeConst = 1'b1; carryIn = 1'b0; #1;
    check("R5 constant one", carryOut, 1'b1);
    cascadeConst = 1'b0; carryIn = 1'b1; #1;
    check("R5 constant zero", carryOut, 1'b0);
    cascadeSel = 1'b1; #1;
    check("R5 carry input", carryOut, 1'b1);

    // R9: set/reset ignored on combinational cells
    for (int i = 0; i < CELLS; i++) lutTable[i] = tablePass0();
    driveIn0(8'h5A); setReset = 1'b1; #1;
    check("R9 comb unaffected", cellOut, 8'h5A);
    stepRise();
    check("R9 comb after edge", cellOut, 8'h5A);
    setReset = 1'b0;

    // R2/R6: clocked register, enable and clocked preset
    stepFall();
    ffEnable = '1; asyncMode = '0; clkEn = 1'b1; driveIn0(8'h3C);
    stepRise();
    check("R6 capture", cellOut, 8'h3C);
    driveIn0(8'hC3); #1;
    check("R2 registered holds", cellOut, 8'h3C);
    clkEn = 1'b0;
    stepRise();
    check("R6 hold when disabled", cellOut, 8'h3C);
    clkEn = 1'b1;
    stepRise();
    check("R6 capture again", cellOut, 8'hC3);
    setReset = 1'b1; clkEn = 1'b0;
    stepRise();
    check("R6 preset gated by enable", cellOut, 8'hC3);
    clkEn = 1'b1;
    stepRise();
    check("R6 preset loaded", cellOut, 8'hA5);
    setReset = 1'b0;

    // R7: immediate preset
    asyncMode = '1; resetValue = 8'h0F; driveIn0(8'h99);
    stepRise();
    check("R7 normal capture", cellOut, 8'h99);
    clkEn = 1'b0; #3;
    setReset = 1'b1; #1;
    check("R7 force without edge", cellOut, 8'h0F);
    stepRise();
    check("R7 force held", cellOut, 8'h0F);
    setReset = 1'b0; clkEn = 1'b1;
    stepRise();
    check("R7 resume capture", cellOut, 8'h99);

    // R6/R7 mixed per cell: upper nibble immediate, lower clocked
    asyncMode = 8'hF0; #3;
    setReset = 1'b1; #1;
    check("R7 mixed before edge", cellOut, 8'h09);
    stepRise();
    check("R6 mixed after edge", cellOut, 8'h0F);
    setReset = 1'b0; asyncMode = '0;

    // R8: falling-edge capture (switch while clk high)
    driveIn0(8'h55);
    stepRise();
    check("R8 rising mode capture", cellOut, 8'h55);
    fallingEdge = 1'b1; driveIn0(8'h66); #2;
    check("R8 no early change", cellOut, 8'h55);
    stepFall();
    check("R8 falling capture", cellOut, 8'h66);
    driveIn0(8'h77);
    stepRise();
    check("R8 rising ignored", cellOut, 8'h66);
    stepFall();
    check("R8 falling capture again", cellOut, 8'h77);
    fallingEdge = 1'b0;

    stepRise();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

endmodule